// File: doc/BRIEF.md
# Output Status Monitor Diagnostic Logic

This block is the digital half of an output-state diagnosis for a bank of power switch channels. Each channel feeds in two comparator results, one for the low-side sense path and one for the high-side sense path, together with its side configuration, its on/off command and its open-load test current enable. The block picks the comparator that matches the channel's side and qualifies the result with the supply state. It snapshots the per-channel status word only when a read strobe arrives, so software sees the outputs as they were at the moment of the read.

Every channel has its own settling timer. The timer restarts whenever the channel's on/off command toggles or its effective test current turns on. Each read returns a per-channel "unsettled" word next to the status word. An aggregated open-load-in-off flag is formed at the same read. It counts only channels that are off, have their test current active and have settled. A global disable forces every test current enable low. Diagnostic results never feed back into channel switching.

Top module: `osm_diag`

## Requirements
- R1: A channel with side bit 0 (low-side) reports status 1 exactly when its low-side comparator input is 1; its high-side comparator input has no effect.
- R2: A channel with side bit 1 (high-side) reports status 1 exactly when its high-side comparator input is 1; its low-side comparator input has no effect.
- R3: Status, unsettled word and aggregated flag are captured only at a clock edge where the read strobe is 1, and they hold between reads. The read-valid output is 1 in the cycle after each strobe cycle.
- R4: The test current drive output equals the enable word ANDed with the inverse of the global disable, one cycle after the inputs. While the disable is 1 the drive is all zeros.
- R5: If a channel's on/off command toggles before edge k, a read captured at edges k through k+SETTLE_CYC reports that channel unsettled. A read at edge k+SETTLE_CYC+1 reports it settled when no further event occurs.
- R6: A rising edge of a channel's effective test current enable (enable AND NOT disable) starts the same settling window as R5. A falling edge does not.
- R7: The aggregated flag is the OR, over channels, of status AND command off AND effective test current enabled AND settled, all taken at the read edge.
- R8: While the supply-normal input is 0 or the logic-undervoltage input is 1, a read returns all status bits 0 and the aggregated flag 0.
- R9: After reset, every captured output, the read-valid output and the drive output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| side_hs_i | input | N_CH | Per-channel side: 1 high-side, 0 low-side |
| cmp_ls_i | input | N_CH | Low-side comparator: sensed drain-source voltage below threshold |
| cmp_hs_i | input | N_CH | High-side comparator: sensed output voltage above threshold |
| ch_on_i | input | N_CH | Per-channel on command |
| iol_en_i | input | N_CH | Per-channel test current enable |
| ol_dis_i | input | 1 | Global open-load detection disable |
| supply_ok_i | input | 1 | Main supply in normal range |
| vdd_uv_i | input | 1 | Logic supply undervoltage |
| rd_stb_i | input | 1 | Read strobe, one cycle |
| rd_status_o | output | N_CH | Captured status word |
| rd_unsettled_o | output | N_CH | Captured per-channel unsettled word |
| rd_oloff_o | output | 1 | Captured aggregated open-load-in-off flag |
| rd_valid_o | output | 1 | Captured data is fresh |
| iol_drive_o | output | N_CH | Test current source enables |

## Verification
A read strobe can land in the same cycle as a settle-restarting event: an on/off toggle or a test-current enable rising, including one caused by dropping the global disable. The bench drives the event and the strobe at the same falling edge. It expects the affected channel to read unsettled and to be left out of the aggregated flag, while settled channels in the same read still count. The last window cycle and the first settled cycle are both read to pin the boundary.

// File: rtl/osm_pkg.sv
package osm_pkg;
  typedef enum logic {
    SIDE_LOW  = 1'b0,
    SIDE_HIGH = 1'b1
  } osm_side_e;

  // picks the comparator that belongs to the configured side
  function automatic logic osm_pick(input osm_side_e side, input logic ls, input logic hs);
    return (side == SIDE_HIGH) ? hs : ls;
  endfunction
endpackage

// File: rtl/osm_status_sel.sv
module osm_status_sel #(
  parameter int N_CH = 8
) (
  input  logic [N_CH-1:0] side_hs_i,
  input  logic [N_CH-1:0] cmp_ls_i,
  input  logic [N_CH-1:0] cmp_hs_i,
  input  logic            supply_ok_i,
  input  logic            vdd_uv_i,
  output logic [N_CH-1:0] status_o
);
  import osm_pkg::*;

  logic diag_ok;
  assign diag_ok = supply_ok_i & ~vdd_uv_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    osm_side_e side;
    assign side        = osm_side_e'(side_hs_i[g]);
    assign status_o[g] = diag_ok & osm_pick(side, cmp_ls_i[g], cmp_hs_i[g]);
  end
endmodule

// File: rtl/osm_settle_timer.sv
module osm_settle_timer #(
  parameter int SETTLE_CYC = 16,
  localparam int CNT_W     = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic on_i,
  input  logic iol_eff_i,
  output logic iol_q_o,
  output logic unsettled_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC);

  logic             on_q;
  logic             iol_q;
  logic [CNT_W-1:0] cnt;
  logic             restart;

  // a toggle of the command or a rising test current restarts the window
  assign restart = (on_i ^ on_q) | (iol_eff_i & ~iol_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q  <= 1'b0;
      iol_q <= 1'b0;
      cnt   <= '0;
    end else begin
      on_q  <= on_i;
      iol_q <= iol_eff_i;
      if (restart)
        cnt <= LOAD;
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign iol_q_o     = iol_q;
  assign unsettled_o = restart | (cnt != '0);
endmodule

// File: rtl/osm_capture.sv
module osm_capture #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_stb_i,
  input  logic [N_CH-1:0] status_i,
  input  logic [N_CH-1:0] unsettled_i,
  input  logic [N_CH-1:0] ch_on_i,
  input  logic [N_CH-1:0] iol_eff_i,
  output logic [N_CH-1:0] rd_status_o,
  output logic [N_CH-1:0] rd_unsettled_o,
  output logic            rd_oloff_o,
  output logic            rd_valid_o
);
  logic [N_CH-1:0] ol_cand;
  assign ol_cand = status_i & ~ch_on_i & iol_eff_i & ~unsettled_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_status_o    <= '0;
      rd_unsettled_o <= '0;
      rd_oloff_o     <= 1'b0;
      rd_valid_o     <= 1'b0;
    end else begin
      rd_valid_o <= rd_stb_i;
      if (rd_stb_i) begin
        rd_status_o    <= status_i;
        rd_unsettled_o <= unsettled_i;
        rd_oloff_o     <= |ol_cand;
      end
    end
  end
endmodule

// File: rtl/osm_diag.sv
module osm_diag #(
  parameter int N_CH       = 8,
  parameter int SETTLE_CYC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] side_hs_i,
  input  logic [N_CH-1:0] cmp_ls_i,
  input  logic [N_CH-1:0] cmp_hs_i,
  input  logic [N_CH-1:0] ch_on_i,
  input  logic [N_CH-1:0] iol_en_i,
  input  logic            ol_dis_i,
  input  logic            supply_ok_i,
  input  logic            vdd_uv_i,
  input  logic            rd_stb_i,
  output logic [N_CH-1:0] rd_status_o,
  output logic [N_CH-1:0] rd_unsettled_o,
  output logic            rd_oloff_o,
  output logic            rd_valid_o,
  output logic [N_CH-1:0] iol_drive_o
);
  logic [N_CH-1:0] iol_eff;
  logic [N_CH-1:0] status;
  logic [N_CH-1:0] unsettled;

  assign iol_eff = iol_en_i & {N_CH{~ol_dis_i}};

  osm_status_sel #(.N_CH(N_CH)) u_sel (
    .side_hs_i   (side_hs_i),
    .cmp_ls_i    (cmp_ls_i),
    .cmp_hs_i    (cmp_hs_i),
    .supply_ok_i (supply_ok_i),
    .vdd_uv_i    (vdd_uv_i),
    .status_o    (status)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_tmr
    osm_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
      .clk         (clk),
      .rst         (rst),
      .on_i        (ch_on_i[g]),
      .iol_eff_i   (iol_eff[g]),
      .iol_q_o     (iol_drive_o[g]),
      .unsettled_o (unsettled[g])
    );
  end

  osm_capture #(.N_CH(N_CH)) u_cap (
    .clk            (clk),
    .rst            (rst),
    .rd_stb_i       (rd_stb_i),
    .status_i       (status),
    .unsettled_i    (unsettled),
    .ch_on_i        (ch_on_i),
    .iol_eff_i      (iol_eff),
    .rd_status_o    (rd_status_o),
    .rd_unsettled_o (rd_unsettled_o),
    .rd_oloff_o     (rd_oloff_o),
    .rd_valid_o     (rd_valid_o)
  );
endmodule

// File: rtl/osm_diag_chk.sv
module osm_diag_chk #(
  parameter int N_CH = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            ol_dis_i,
  input logic            supply_ok_i,
  input logic            vdd_uv_i,
  input logic            rd_stb_i,
  input logic [N_CH-1:0] rd_status_o,
  input logic [N_CH-1:0] rd_unsettled_o,
  input logic            rd_oloff_o,
  input logic            rd_valid_o,
  input logic [N_CH-1:0] iol_drive_o
);
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_stb_i |=> ($stable(rd_status_o) && $stable(rd_unsettled_o) && $stable(rd_oloff_o))); // R3
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_stb_i |=> rd_valid_o); // R3
  AST_DISABLE_KILLS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    ol_dis_i |=> (iol_drive_o == '0)); // R4
  AST_BAD_SUPPLY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && (!supply_ok_i || vdd_uv_i)) |=> (rd_status_o == '0 && !rd_oloff_o)); // R8
  AST_OLOFF_NEEDS_SETTLED_BIT: assert property (@(posedge clk) disable iff (rst)
    rd_oloff_o |-> ((rd_status_o & ~rd_unsettled_o) != '0)); // R7
endmodule

bind osm_diag osm_diag_chk #(.N_CH(N_CH)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .ol_dis_i       (ol_dis_i),
  .supply_ok_i    (supply_ok_i),
  .vdd_uv_i       (vdd_uv_i),
  .rd_stb_i       (rd_stb_i),
  .rd_status_o    (rd_status_o),
  .rd_unsettled_o (rd_unsettled_o),
  .rd_oloff_o     (rd_oloff_o),
  .rd_valid_o     (rd_valid_o),
  .iol_drive_o    (iol_drive_o)
);

// File: tb/osm_diag_tb.sv
`timescale 1ns/1ps
module osm_diag_tb;
  localparam int N = 8;
  localparam int S = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] side_hs = 8'hF0;
  logic [N-1:0] cmp_ls = '0, cmp_hs = '0, ch_on = '0, iol_en = '0;
  logic         ol_dis = 1'b0, supply_ok = 1'b1, vdd_uv = 1'b0, rd_stb = 1'b0;
  logic [N-1:0] rd_status, rd_uns, iol_drive;
  logic         rd_oloff, rd_valid;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [N-1:0] st;
    logic [N-1:0] un;
    logic         ol;
    string        req;
  } exp_t;
  exp_t scb[$];

  always #2 clk = ~clk;

  osm_diag #(.N_CH(N), .SETTLE_CYC(S)) u_dut (
    .clk(clk), .rst(rst), .side_hs_i(side_hs), .cmp_ls_i(cmp_ls), .cmp_hs_i(cmp_hs),
    .ch_on_i(ch_on), .iol_en_i(iol_en), .ol_dis_i(ol_dis), .supply_ok_i(supply_ok),
    .vdd_uv_i(vdd_uv), .rd_stb_i(rd_stb), .rd_status_o(rd_status),
    .rd_unsettled_o(rd_uns), .rd_oloff_o(rd_oloff), .rd_valid_o(rd_valid),
    .iol_drive_o(iol_drive)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: strobe a read and queue what it must return
  task automatic rd(input logic [N-1:0] st, input logic [N-1:0] un, input logic ol, input string req);
    exp_t e;
    e.st = st; e.un = un; e.ol = ol; e.req = req;
    scb.push_back(e);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  // monitor: compare each fresh read against the queue
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (scb.size() == 0) begin
        chk("R3 unexpected valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = scb.pop_front();
        chk({e.req, " status"}, 32'(rd_status), 32'(e.st));
        chk({e.req, " unsettled"}, 32'(rd_uns), 32'(e.un));
        chk({e.req, " oloff"}, 32'(rd_oloff), 32'(e.ol));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    // R9 reset state
    chk("R9 status", 32'(rd_status), 0);
    chk("R9 unsettled", 32'(rd_uns), 0);
    chk("R9 oloff", 32'(rd_oloff), 0);
    chk("R9 valid", 32'(rd_valid), 0);
    chk("R9 drive", 32'(iol_drive), 0);

    // R1 R2 side selection, two patterns
    cmp_ls = 8'h05; cmp_hs = 8'h30;
    rd(8'h35, 8'h00, 1'b0, "R1 R2 pattern A");
    cmp_ls = 8'hFA; cmp_hs = 8'h0C;
    rd(8'h0A, 8'h00, 1'b0, "R1 R2 pattern B");

    // R3: no read, no change
    cmp_ls = 8'h00; cmp_hs = 8'hFF;
    tick(3);
    chk("R3 hold status", 32'(rd_status), 32'h0A);
    chk("R3 valid low", 32'(rd_valid), 0);
    rd(8'hF0, 8'h00, 1'b0, "R3 refresh");

    // R4 drive gating
    iol_en = 8'hFF;
    tick(1);
    chk("R4 drive on", 32'(iol_drive), 32'hFF);
    ol_dis = 1'b1;
    tick(1);
    chk("R4 drive forced off", 32'(iol_drive), 0);
    ol_dis = 1'b0; iol_en = 8'h00;
    tick(1);
    chk("R4 drive off", 32'(iol_drive), 0);
    tick(S + 2);

    // R6 window after enable rise, R7 aggregation
    cmp_ls = 8'h05; cmp_hs = 8'h00; iol_en = 8'h03;
    rd(8'h05, 8'h03, 1'b0, "R6 same edge");
    tick(S - 1);
    rd(8'h05, 8'h03, 1'b0, "R6 last window edge");
    rd(8'h05, 8'h00, 1'b1, "R6 R7 settled");

    // R5 window after toggle; on channels excluded (R7)
    ch_on = 8'h01;
    rd(8'h05, 8'h01, 1'b0, "R5 toggle on");
    tick(S - 1);
    rd(8'h05, 8'h01, 1'b0, "R5 last window edge");
    rd(8'h05, 8'h00, 1'b0, "R5 R7 on excluded");
    cmp_ls = 8'h07;
    rd(8'h07, 8'h00, 1'b1, "R7 off channel counts");
    ch_on = 8'h00;
    rd(8'h07, 8'h01, 1'b1, "R5 R7 toggle off, other settled");
    tick(S + 2);

    // R8 supply gating
    supply_ok = 1'b0;
    rd(8'h00, 8'h00, 1'b0, "R8 supply low");
    supply_ok = 1'b1; vdd_uv = 1'b1;
    rd(8'h00, 8'h00, 1'b0, "R8 logic undervoltage");
    vdd_uv = 1'b0;
    rd(8'h07, 8'h00, 1'b1, "R8 restored");

    // R4 R7 disable clears flag; R6 re-enable restarts window
    ol_dis = 1'b1;
    rd(8'h07, 8'h00, 1'b0, "R4 R7 disabled");
    ol_dis = 1'b0;
    rd(8'h07, 8'h03, 1'b0, "R6 disable release");

    tick(3);
    chk("R3 scoreboard drained", 32'(scb.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule